// File: doc/BRIEF.md
# Trace Capture Controller

This block runs the storage side of a debug trace session. When software arms a run, the block clears its status and begins recording into a small on-chip trace buffer. What it records depends on the mode chosen when the run is armed. In the two address modes it records the targets of change-of-flow events. In event-only mode it records one bus data byte per qualified event. Deciding which bus cycle counts as a trigger or an event is done upstream; this block receives those decisions as one-cycle strobes.

There are three capture styles. In start-on-trigger capture, nothing is kept until the qualified trigger arrives, and the run ends when the buffer fills. In circular capture, every change-of-flow target is kept from the moment of arming, the oldest entry is overwritten once the buffer is full, and the run ends on the trigger. Event-only capture always behaves as start-on-trigger, whatever the begin/end selection says. Software can end any run early with a control write. Once the run is over, the entries are read oldest-first through a read strobe.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset the run is not armed, both hit flags are 0 and the entry count is 0.
- R2: A control write with arm=1 and enable=1 sets the armed flag one cycle later. The same write clears both hit flags and the entry count, and latches the mode inputs for the run.
- R3: In start-on-trigger capture (mode_begin=1, mode_event_only=0), a change-of-flow address is stored only from the cycle of the qualified trigger onward. The run disarms on the edge where the count reaches DEPTH (8).
- R4: In circular capture (mode_begin=0, mode_event_only=0), every change-of-flow address is stored from arming. When the buffer is full, the oldest entry is overwritten and the count stays at DEPTH. A qualified trigger disarms the run, and an address in the trigger cycle is still stored.
- R5: In event-only capture (mode_event_only=1, mode_begin ignored), each event strobe stores bus_data in bits [7:0] of an entry with bits [15:8] zero. Change-of-flow strobes and the trigger are ignored. The run disarms when the count reaches DEPTH.
- R6: A control write with arm=0 or enable=0 disarms the run at the next edge. No entry is stored in that cycle, and the count is kept.
- R7: hit_a and hit_b set the matching sticky flags only while armed. The flags stay set until the next arming write.
- R8: When not armed and the count is non-zero, rd_data shows the oldest entry and rd_en advances to the next entry while decrementing the count. rd_en has no effect while armed or when the buffer is empty.
- R9: The entry count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_arm | input | 1 | Arm bit value of the write |
| ctl_en | input | 1 | Module enable bit value of the write |
| mode_begin | input | 1 | 1 = start on trigger, 0 = circular until trigger |
| mode_event_only | input | 1 | 1 = store data bytes on events |
| trig_qual | input | 1 | Qualified trigger strobe |
| hit_a | input | 1 | Comparator A hit strobe |
| hit_b | input | 1 | Comparator B hit strobe |
| cof_valid | input | 1 | Change-of-flow address valid |
| cof_addr | input | 16 | Change-of-flow target address |
| evt_strobe | input | 1 | Event-only store strobe |
| bus_data | input | 8 | Bus data byte |
| rd_en | input | 1 | Read strobe, pops the oldest entry |
| rd_data | output | 16 | Oldest stored entry |
| run_armed | output | 1 | Run in progress |
| flag_a | output | 1 | Sticky comparator A hit |
| flag_b | output | 1 | Sticky comparator B hit |
| entry_count | output | 4 | Number of readable entries |

## Verification
A wrong capture style or a lost start latch shows up first as an entry count that differs from the expected one, one cycle after the offending strobe. A wrong end-of-run decision shows up on run_armed at that same edge. Pointer errors stay hidden during capture. They appear only when the buffer is drained, where rd_data returns entries in the wrong order or values that were never written. The bench therefore reads back every entry of each run and compares the sequence, not just the count.

// File: rtl/trace_cap_pkg.sv
// Package: shared capture-style encoding for the trace capture controller.
// Assumes: style is decided once per run at arming time.
package trace_cap_pkg;

    typedef enum logic [1:0] {
        STYLE_BEGIN = 2'd0,
        STYLE_END   = 2'd1,
        STYLE_EVENT = 2'd2
    } cap_style_e;

    // Event-only mode overrides the begin/end selection.
    function automatic cap_style_e pick_style(input logic event_only, input logic begin_sel);
        if (event_only)
            return STYLE_EVENT;
        else if (begin_sel)
            return STYLE_BEGIN;
        else
            return STYLE_END;
    endfunction

endpackage

// File: rtl/trace_fifo.sv
// Module: trace_fifo
// Circular store of DEPTH entries. A write to a full buffer overwrites the
// oldest entry and holds the count at DEPTH. A read pops the oldest entry.
// Assumes: the caller never asserts wr_en and rd_en in the same cycle,
// and never reads an empty buffer. clear has priority over everything.
module trace_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [AW-1:0]    rd_data,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [AW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;

    assign full    = (count == FULL_CNT);
    assign rd_data = mem[rd_ptr];

    // Advance a pointer with explicit wrap so DEPTH need not be a power of two.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Storage array: written on every accepted write, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en && !clear)
            mem[wr_ptr] <= wr_data;
    end

    // Pointers and count: clear, write with overwrite, or read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            wr_ptr <= bump(wr_ptr);
            if (full)
                rd_ptr <= bump(rd_ptr);
            else
                count <= count + 1'b1;
        end else if (rd_en) begin
            rd_ptr <= bump(rd_ptr);
            count  <= count - 1'b1;
        end
    end

endmodule

// File: rtl/trace_store_sel.sv
// Module: trace_store_sel
// Decides, cycle by cycle, whether an entry is stored and what it holds.
// Address styles store change-of-flow targets. Event style stores the
// zero-extended bus data byte.
// Assumes: halt is high in any cycle carrying a control write.
module trace_store_sel
    import trace_cap_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          armed,
    input  logic          halt,
    input  cap_style_e    style,
    input  logic          started,
    input  logic          trig_qual,
    input  logic          cof_valid,
    input  logic [AW-1:0] cof_addr,
    input  logic          evt_strobe,
    input  logic [DW-1:0] bus_data,
    output logic          store_en,
    output logic [AW-1:0] store_data
);

    logic          live;
    logic [AW-1:0] evt_word;

    assign live = armed && !halt;

    // Fit the data byte into an entry: zero-pad or truncate by width.
    generate
        if (AW > DW) begin : g_pad
            assign evt_word = {{(AW-DW){1'b0}}, bus_data};
        end else begin : g_trunc
            assign evt_word = bus_data[AW-1:0];
        end
    endgenerate

    // Per-style store decision and entry content.
    always_comb begin
        store_en   = 1'b0;
        store_data = cof_addr;
        unique case (style)
            STYLE_BEGIN: store_en = live && cof_valid && (started || trig_qual);
            STYLE_END:   store_en = live && cof_valid;
            STYLE_EVENT: begin
                store_en   = live && evt_strobe;
                store_data = evt_word;
            end
            default:     store_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/trace_run_ctl.sv
// Module: trace_run_ctl
// Run state: armed flag, start-on-trigger latch, sticky hit flags and the
// latched capture style. Decodes control writes into start and stop.
// Assumes: store_en and count come from the store selector and the buffer.
module trace_run_ctl
    import trace_cap_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_arm,
    input  logic             ctl_en,
    input  logic             mode_begin,
    input  logic             mode_event_only,
    input  logic             trig_qual,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic             store_en,
    input  logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             started,
    output cap_style_e       style,
    output logic             flag_a,
    output logic             flag_b,
    output logic             arm_start,
    output logic             halt
);

    localparam logic [CNT_W-1:0] NEAR_FULL = CNT_W'(DEPTH - 1);

    logic arm_stop;
    logic fill_end;
    logic trig_end;

    assign arm_start = ctl_wr && ctl_arm && ctl_en;
    assign arm_stop  = ctl_wr && !(ctl_arm && ctl_en);
    assign halt      = ctl_wr;
    assign fill_end  = store_en && (style != STYLE_END) && (count == NEAR_FULL);
    assign trig_end  = (style == STYLE_END) && trig_qual;

    // Armed flag: set by arming, cleared by stop, fill or end trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (arm_start)
            armed <= 1'b1;
        else if (arm_stop)
            armed <= 1'b0;
        else if (armed && (fill_end || trig_end))
            armed <= 1'b0;
    end

    // Capture style: latched once per run at arming.
    always_ff @(posedge clk) begin
        if (!rst_n)
            style <= STYLE_BEGIN;
        else if (arm_start)
            style <= pick_style(mode_event_only, mode_begin);
    end

    // Start latch: remembers that the trigger has arrived in begin style.
    always_ff @(posedge clk) begin
        if (!rst_n || arm_start)
            started <= 1'b0;
        else if (armed && !halt && trig_qual && (style == STYLE_BEGIN))
            started <= 1'b1;
    end

    // Sticky hit flags: set only while armed, cleared by arming.
    always_ff @(posedge clk) begin
        if (!rst_n || arm_start) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else if (armed) begin
            flag_a <= flag_a | hit_a;
            flag_b <= flag_b | hit_b;
        end
    end

endmodule

// File: rtl/trace_capture_ctrl.sv
// Module: trace_capture_ctrl (top)
// Trace capture controller: ties run control, store selection and the
// circular trace buffer together. The buffer is readable only between runs.
// Assumes: trigger and event qualification are done upstream.
module trace_capture_ctrl
    import trace_cap_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_arm,
    input  logic             ctl_en,
    input  logic             mode_begin,
    input  logic             mode_event_only,
    input  logic             trig_qual,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic             cof_valid,
    input  logic [AW-1:0]    cof_addr,
    input  logic             evt_strobe,
    input  logic [DW-1:0]    bus_data,
    input  logic             rd_en,
    output logic [AW-1:0]    rd_data,
    output logic             run_armed,
    output logic             flag_a,
    output logic             flag_b,
    output logic [CNT_W-1:0] entry_count
);

    cap_style_e    style;
    logic          started;
    logic          arm_start;
    logic          halt;
    logic          store_en;
    logic [AW-1:0] store_data;
    logic          rd_ok;

    // Reads are honoured only between runs and when something is stored.
    assign rd_ok = rd_en && !run_armed && (entry_count != '0);

    trace_run_ctl #(.DEPTH(DEPTH)) u_run (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_wr          (ctl_wr),
        .ctl_arm         (ctl_arm),
        .ctl_en          (ctl_en),
        .mode_begin      (mode_begin),
        .mode_event_only (mode_event_only),
        .trig_qual       (trig_qual),
        .hit_a           (hit_a),
        .hit_b           (hit_b),
        .store_en        (store_en),
        .count           (entry_count),
        .armed           (run_armed),
        .started         (started),
        .style           (style),
        .flag_a          (flag_a),
        .flag_b          (flag_b),
        .arm_start       (arm_start),
        .halt            (halt)
    );

    trace_store_sel #(.AW(AW), .DW(DW)) u_sel (
        .armed      (run_armed),
        .halt       (halt),
        .style      (style),
        .started    (started),
        .trig_qual  (trig_qual),
        .cof_valid  (cof_valid),
        .cof_addr   (cof_addr),
        .evt_strobe (evt_strobe),
        .bus_data   (bus_data),
        .store_en   (store_en),
        .store_data (store_data)
    );

    trace_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (arm_start),
        .wr_en   (store_en),
        .wr_data (store_data),
        .rd_en   (rd_ok),
        .rd_data (rd_data),
        .count   (entry_count)
    );

endmodule

// File: rtl/trace_capture_chk.sv
// Module: trace_capture_chk
// Port-level properties of the trace capture controller, bound to the top.
module trace_capture_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_arm,
    input logic             ctl_en,
    input logic             rd_en,
    input logic             run_armed,
    input logic             flag_a,
    input logic             flag_b,
    input logic [CNT_W-1:0] entry_count
);

    logic start_w;
    assign start_w = ctl_wr && ctl_arm && ctl_en;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_W'(DEPTH)); // R9
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> run_armed && entry_count == '0 && !flag_a && !flag_b); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !(ctl_arm && ctl_en) && run_armed |=> !run_armed && entry_count == $past(entry_count)); // R6
    AST_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_armed && !ctl_wr && rd_en && entry_count != '0 |=> entry_count == $past(entry_count) - 1'b1); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a || flag_b) && !start_w |=> (flag_a || !$past(flag_a)) && (flag_b || !$past(flag_b))); // R7

endmodule

bind trace_capture_ctrl trace_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_arm     (ctl_arm),
    .ctl_en      (ctl_en),
    .rd_en       (rd_en),
    .run_armed   (run_armed),
    .flag_a      (flag_a),
    .flag_b      (flag_b),
    .entry_count (entry_count)
);

// File: tb/trace_capture_ctrl_bench.sv
// Directed bench for the trace capture controller: one task per scenario.
module trace_capture_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, ctl_arm = 0, ctl_en = 0;
    logic        mode_begin = 0, mode_event_only = 0;
    logic        trig_qual = 0, hit_a = 0, hit_b = 0;
    logic        cof_valid = 0;
    logic [15:0] cof_addr = '0;
    logic        evt_strobe = 0;
    logic [7:0]  bus_data = '0;
    logic        rd_en = 0;
    logic [15:0] rd_data;
    logic        run_armed, flag_a, flag_b;
    logic [3:0]  entry_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trace_capture_ctrl u_trace_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_arm(ctl_arm), .ctl_en(ctl_en),
        .mode_begin(mode_begin), .mode_event_only(mode_event_only),
        .trig_qual(trig_qual), .hit_a(hit_a), .hit_b(hit_b),
        .cof_valid(cof_valid), .cof_addr(cof_addr), .evt_strobe(evt_strobe),
        .bus_data(bus_data), .rd_en(rd_en), .rd_data(rd_data),
        .run_armed(run_armed), .flag_a(flag_a), .flag_b(flag_b),
        .entry_count(entry_count)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ctl(input logic arm, input logic en);
        ctl_wr = 1; ctl_arm = arm; ctl_en = en;
        step();
        ctl_wr = 0; ctl_arm = 0; ctl_en = 0;
    endtask

    task automatic cof(input logic [15:0] a, input logic trig);
        cof_valid = 1; cof_addr = a; trig_qual = trig;
        step();
        cof_valid = 0; trig_qual = 0;
    endtask

    task automatic drain(input string req, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            chk(req, rd_data, base + i);
            rd_en = 1;
            step();
            rd_en = 0;
            chk(req, entry_count, n - 1 - i);
        end
    endtask

    task automatic t_reset();
        chk("R1 armed", run_armed, 0);
        chk("R1 flags", {flag_a, flag_b}, 0);
        chk("R1 count", entry_count, 0);
    endtask

    task automatic t_begin();
        mode_begin = 1; mode_event_only = 0;
        ctl(1, 1);
        chk("R2 armed", run_armed, 1);
        cof(16'h1000, 0);
        cof(16'h1001, 0);
        chk("R3 no store before trigger", entry_count, 0);
        cof(16'h2000, 1);
        chk("R3 trigger cycle stored", entry_count, 1);
        for (int i = 1; i < 7; i++) cof(16'h2000 + 16'(i), 0);
        chk("R3 still armed at 7", run_armed, 1);
        cof(16'h2007, 0);
        chk("R3 full ends run", run_armed, 0);
        chk("R3 count full", entry_count, 8);
        cof(16'h3000, 0);
        chk("R3 no store after end", entry_count, 8);
        drain("R8 begin readback", 8, 16'h2000);
    endtask

    task automatic t_end();
        mode_begin = 0; mode_event_only = 0;
        ctl(1, 1);
        for (int i = 0; i < 11; i++) cof(16'h4000 + 16'(i), 0);
        chk("R4 count saturates", entry_count, 8);
        chk("R4 still armed", run_armed, 1);
        cof(16'h400B, 1);
        chk("R4 trigger ends run", run_armed, 0);
        drain("R4 newest kept", 8, 16'h4004);
    endtask

    task automatic t_event();
        mode_begin = 0; mode_event_only = 1;
        ctl(1, 1);
        mode_event_only = 0;
        cof(16'h5555, 1);
        chk("R5 trigger ignored", run_armed, 1);
        chk("R5 cof ignored", entry_count, 0);
        for (int i = 0; i < 8; i++) begin
            evt_strobe = 1; bus_data = 8'hA0 + 8'(i);
            step();
            evt_strobe = 0;
            if (i == 6) chk("R5 armed at 7", run_armed, 1);
        end
        chk("R5 full ends run", run_armed, 0);
        drain("R5 data bytes", 8, 16'h00A0);
    endtask

    task automatic t_stop();
        mode_begin = 0; mode_event_only = 0;
        ctl(1, 1);
        for (int i = 0; i < 3; i++) cof(16'h6000 + 16'(i), 0);
        cof_valid = 1; cof_addr = 16'h6FFF;
        ctl(0, 1);
        cof_valid = 0;
        chk("R6 arm=0 stops", run_armed, 0);
        chk("R6 stop cycle not stored", entry_count, 3);
        ctl(1, 1);
        cof(16'h7000, 0);
        cof(16'h7001, 0);
        ctl(1, 0);
        chk("R6 en=0 stops", run_armed, 0);
        chk("R6 count kept", entry_count, 2);
        drain("R6 readback", 2, 16'h7000);
    endtask

    task automatic t_flags();
        hit_a = 1; hit_b = 1;
        step();
        hit_a = 0; hit_b = 0;
        chk("R7 ignored when idle", {flag_a, flag_b}, 0);
        mode_begin = 0; mode_event_only = 0;
        ctl(1, 1);
        hit_a = 1; step(); hit_a = 0;
        chk("R7 a set", {flag_a, flag_b}, 2);
        hit_b = 1; step(); hit_b = 0;
        step(); step();
        chk("R7 sticky", {flag_a, flag_b}, 3);
        cof(16'h8000, 0);
        cof(16'h8001, 0);
        rd_en = 1; step(); rd_en = 0;
        chk("R8 read ignored while armed", entry_count, 2);
        ctl(0, 0);
        chk("R7 flags kept after stop", {flag_a, flag_b}, 3);
        chk("R8 oldest first", rd_data, 16'h8000);
        rd_en = 1; step(); rd_en = 0;
        chk("R8 pop", entry_count, 1);
        chk("R8 next", rd_data, 16'h8001);
        ctl(1, 1);
        chk("R2 flags cleared", {flag_a, flag_b}, 0);
        chk("R2 count cleared", entry_count, 0);
        ctl(0, 1);
        rd_en = 1; step(); rd_en = 0;
        chk("R8 empty read ignored", entry_count, 0);
    endtask

    initial begin
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_begin();
        t_end();
        t_event();
        t_stop();
        t_flags();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule